// File: doc/BRIEF.md
# Receive Skew Pre-Aligner

This block runs a single corrective pass on one byte lane before receive-window centering. It takes the per-bit left and right edges that an edge search found with one stress pattern, reduces them to the latest start and the earliest end across the lane, and reports the window width. When the window is pressed against the low end of the delay range, every bit's 5-bit receive delay is raised by a fixed step. When it is pressed against the high end, only two fixed pad delays are raised. Each update is a read-modify-write over a narrow internal register port, and the result saturates at the largest delay code.

The pass is guarded per chip select. The first request for a chip select marks it as handled, and later requests for it finish at once with success and touch nothing. A lane whose search did not lock on both sides ends with a failure flag. The block's reset clears the chip-select guard.

Top module: `rx_skew_prealign`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `rd_en` and `wr_en` are 0, `win_size` is 0, and every chip select's run-once mark is cleared.
- R2: A `start` seen while idle, for a chip select whose mark is already set, gives `done`=1 with `fail`=0 in the next cycle, with no register access and no change to `win_size`.
- R3: A `start` for an unmarked chip select with `lock_lo2hi` or `lock_hi2lo` low sets the mark, gives `done`=1 with `fail`=1 in the next cycle, makes no register access and leaves `win_size` unchanged.
- R4: On a locked, unmarked run `win_size` becomes (smallest end edge − largest start edge + 1), as a two's-complement value of EDGE_W+2 bits. Bit i's start edge is `edge_start[i*EDGE_W +: EDGE_W]`, and its end edge sits at the same position in `edge_end`.
- R5: Left fix: when the largest start edge is 1 or less, the delay at pad `pad_map[i*PAD_W +: PAD_W]` is updated for each bit i, in order from i=0 upward.
- R6: Right fix: when the smallest end edge is greater than 30, the delays at pad 4 and then pad 5 are updated. A largest start of 2, or a smallest end of 30, triggers no update.
- R7: When both fixes apply, all left-fix updates come before the two right-fix updates.
- R8: Each update takes two cycles. In the first, `rd_en`=1 with `reg_addr` set. In the second, `wr_en`=1 with the same address and `wr_data` = min(`rd_data` + 10, 31), where `rd_data` is returned one cycle after `rd_en`.
- R9: `busy` is high from the cycle after an accepted `start` through the single-cycle `done` pulse, which follows the last write, or follows `start` directly when there is nothing to update. A `start` while busy is ignored and does not mark its chip select.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also clears the run-once marks |
| start | input | 1 | Request a pass for `cs_sel` (taken only when idle) |
| cs_sel | input | $clog2(NCS) | Chip select of this pass |
| lock_lo2hi | input | 1 | Low-to-high search locked |
| lock_hi2lo | input | 1 | High-to-low search locked |
| edge_start | input | NBITS*EDGE_W | Per-bit start edges |
| edge_end | input | NBITS*EDGE_W | Per-bit end edges |
| pad_map | input | NBITS*PAD_W | Bit-to-pad lookup |
| rd_data | input | DLY_W | Delay register read data, one cycle after `rd_en` |
| rd_en | output | 1 | Delay register read strobe |
| wr_en | output | 1 | Delay register write strobe |
| reg_addr | output | PAD_W | Pad index of the access |
| wr_data | output | DLY_W | Saturated delay written back |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| fail | output | 1 | Lock failure, valid with `done` |
| win_size | output | EDGE_W+2 | Lane window width, two's complement |

## Verification
The bench keeps the default parameters: eight bits, 6-bit edges, 4-bit pad indices over a twelve-entry delay bank, and four chip selects. With four chip selects it can mark all of them before a reset, and then show that the reset brings them back into use. With a step of 10 and a cap of 31, saturation is reached from any seed of 22 or more, so the bank is seeded with values on both sides of that point. The edge range reaches 63, so both alignment fixes, the threshold values 2 and 30, and a negative window width are all inside the tested range.

// File: rtl/rxpa_pkg.sv
package rxpa_pkg;

    // Top-level pass phase
    typedef enum logic [1:0] {
        P_IDLE,
        P_RUN,
        P_FIN
    } phase_e;

    // Register access phase of the read-modify-write sequencer
    typedef enum logic [1:0] {
        A_IDLE,
        A_READ,
        A_WRITE
    } acc_e;

    // Which alignment fixes a lane needs
    typedef struct packed {
        logic left;
        logic right;
    } align_t;

    // Add a step and clamp at a cap
    function automatic int unsigned sat_step(input int unsigned v,
                                             input int unsigned step,
                                             input int unsigned cap);
        int unsigned s;
        s = v + step;
        return (s > cap) ? cap : s;
    endfunction

endpackage

// File: rtl/rxpa_edge_reduce.sv
module rxpa_edge_reduce #(
    parameter int NBITS  = 8,
    parameter int EDGE_W = 6
) (
    input  logic [NBITS*EDGE_W-1:0] starts,
    input  logic [NBITS*EDGE_W-1:0] ends,
    output logic [EDGE_W-1:0]       max_start,
    output logic [EDGE_W-1:0]       min_end
);
    always_comb begin
        logic [EDGE_W-1:0] s_v;
        logic [EDGE_W-1:0] e_v;
        max_start = '0;
        min_end   = '1;
        for (int i = 0; i < NBITS; i++) begin
            s_v = starts[i*EDGE_W +: EDGE_W];
            e_v = ends[i*EDGE_W +: EDGE_W];
            if (s_v > max_start) max_start = s_v;
            if (e_v < min_end)   min_end   = e_v;
        end
    end
endmodule

// File: rtl/rxpa_once_guard.sv
module rxpa_once_guard #(
    parameter int NCS  = 4,
    localparam int CS_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CS_W-1:0] cs,
    input  logic            claim,
    output logic            already
);
    logic [NCS-1:0] mark_q;

    assign already = mark_q[cs];

    always_ff @(posedge clk) begin
        if (rst)        mark_q <= '0;
        else if (claim) mark_q[cs] <= 1'b1;
    end
endmodule

// File: rtl/rxpa_rmw_seq.sv
module rxpa_rmw_seq
    import rxpa_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int PAD_W = 4,
    parameter int DLY_W = 5,
    parameter int STEP  = 10,
    parameter int DMAX  = 31,
    parameter int PAD_A = 4,
    parameter int PAD_B = 5,
    localparam int JW   = $clog2(NBITS + 2) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   launch,
    input  align_t                 want,
    input  logic [NBITS*PAD_W-1:0] pad_map,
    input  logic [DLY_W-1:0]       rd_data,
    output logic                   rd_en,
    output logic                   wr_en,
    output logic [PAD_W-1:0]       addr,
    output logic [DLY_W-1:0]       wr_data,
    output logic                   last
);
    acc_e                   st;
    logic [JW-1:0]          job, job_end;
    logic [NBITS*PAD_W-1:0] pad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= A_IDLE;
            job     <= '0;
            job_end <= '0;
            pad_q   <= '0;
        end else begin
            case (st)
                A_IDLE: if (launch) begin
                    pad_q   <= pad_map;
                    job     <= want.left  ? '0 : JW'(NBITS);
                    job_end <= want.right ? JW'(NBITS + 1) : JW'(NBITS - 1);
                    st      <= A_READ;
                end
                A_READ:  st <= A_WRITE;
                A_WRITE: begin
                    if (job == job_end) st <= A_IDLE;
                    else begin
                        job <= job + JW'(1);
                        st  <= A_READ;
                    end
                end
                default: st <= A_IDLE;
            endcase
        end
    end

    // Jobs 0..NBITS-1 follow the lookup, the last two are the fixed pads
    always_comb begin
        addr = (job == JW'(NBITS)) ? PAD_W'(PAD_A) : PAD_W'(PAD_B);
        for (int i = 0; i < NBITS; i++)
            if (job == JW'(i)) addr = pad_q[i*PAD_W +: PAD_W];
    end

    assign rd_en   = (st == A_READ);
    assign wr_en   = (st == A_WRITE);
    assign wr_data = DLY_W'(sat_step(32'(rd_data), STEP, DMAX));
    assign last    = (st == A_WRITE) && (job == job_end);
endmodule

// File: rtl/rx_skew_prealign.sv
module rx_skew_prealign
    import rxpa_pkg::*;
#(
    parameter int NBITS     = 8,
    parameter int EDGE_W    = 6,
    parameter int PAD_W     = 4,
    parameter int DLY_W     = 5,
    parameter int NCS       = 4,
    parameter int STEP      = 10,
    parameter int DMAX      = 31,
    parameter int LEFT_LIM  = 1,
    parameter int RIGHT_LIM = 30,
    parameter int PAD_A     = 4,
    parameter int PAD_B     = 5,
    localparam int CS_W     = (NCS > 1) ? $clog2(NCS) : 1,
    localparam int WS_W     = EDGE_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [CS_W-1:0]         cs_sel,
    input  logic                    lock_lo2hi,
    input  logic                    lock_hi2lo,
    input  logic [NBITS*EDGE_W-1:0] edge_start,
    input  logic [NBITS*EDGE_W-1:0] edge_end,
    input  logic [NBITS*PAD_W-1:0]  pad_map,
    input  logic [DLY_W-1:0]        rd_data,
    output logic                    rd_en,
    output logic                    wr_en,
    output logic [PAD_W-1:0]        reg_addr,
    output logic [DLY_W-1:0]        wr_data,
    output logic                    busy,
    output logic                    done,
    output logic                    fail,
    output logic [WS_W-1:0]         win_size
);
    phase_e            phase;
    logic              fail_q;
    logic [WS_W-1:0]   win_q;
    logic [EDGE_W-1:0] max_start, min_end;
    logic              already, accept, claim, locked, launch, seq_last;
    align_t            want;
    logic [WS_W-1:0]   win_calc;

    rxpa_edge_reduce #(.NBITS(NBITS), .EDGE_W(EDGE_W)) u_reduce (
        .starts(edge_start), .ends(edge_end),
        .max_start(max_start), .min_end(min_end)
    );

    rxpa_once_guard #(.NCS(NCS)) u_guard (
        .clk(clk), .rst(rst), .cs(cs_sel), .claim(claim), .already(already)
    );

    rxpa_rmw_seq #(
        .NBITS(NBITS), .PAD_W(PAD_W), .DLY_W(DLY_W), .STEP(STEP),
        .DMAX(DMAX), .PAD_A(PAD_A), .PAD_B(PAD_B)
    ) u_seq (
        .clk(clk), .rst(rst), .launch(launch), .want(want),
        .pad_map(pad_map), .rd_data(rd_data), .rd_en(rd_en), .wr_en(wr_en),
        .addr(reg_addr), .wr_data(wr_data), .last(seq_last)
    );

    assign accept     = (phase == P_IDLE) && start;
    assign claim      = accept && !already;
    assign locked     = lock_lo2hi && lock_hi2lo;
    assign want.left  = int'(max_start) <= LEFT_LIM;
    assign want.right = int'(min_end) > RIGHT_LIM;
    assign launch     = claim && locked && (want.left || want.right);
    assign win_calc   = WS_W'(min_end) - WS_W'(max_start) + WS_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= P_IDLE;
            fail_q <= 1'b0;
            win_q  <= '0;
        end else begin
            case (phase)
                P_IDLE: if (start) begin
                    if (already) begin
                        fail_q <= 1'b0;
                        phase  <= P_FIN;
                    end else if (!locked) begin
                        fail_q <= 1'b1;
                        phase  <= P_FIN;
                    end else begin
                        fail_q <= 1'b0;
                        win_q  <= win_calc;
                        phase  <= (want.left || want.right) ? P_RUN : P_FIN;
                    end
                end
                P_RUN:   if (seq_last) phase <= P_FIN;
                P_FIN:   phase <= P_IDLE;
                default: phase <= P_IDLE;
            endcase
        end
    end

    assign busy     = (phase != P_IDLE);
    assign done     = (phase == P_FIN);
    assign fail     = (phase == P_FIN) && fail_q;
    assign win_size = win_q;
endmodule

// File: rtl/rxpa_chk.sv
module rxpa_chk #(
    parameter int PAD_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             fail,
    input logic             rd_en,
    input logic             wr_en,
    input logic [PAD_W-1:0] reg_addr
);
    // R8
    rmw_pair_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (wr_en && $stable(reg_addr)));

    // R8
    access_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_en, wr_en, done}));

    // R9
    access_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |-> busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R3
    fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> !$past(wr_en));
endmodule

bind rx_skew_prealign rxpa_chk #(.PAD_W(PAD_W)) u_rxpa_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .fail(fail),
    .rd_en(rd_en), .wr_en(wr_en), .reg_addr(reg_addr)
);

// File: tb/rx_skew_prealign_bench.sv
module rx_skew_prealign_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 8;
    localparam int EW    = 6;
    localparam int PW    = 4;
    localparam int DW    = 5;
    localparam int NCS   = 4;
    localparam int NPADS = 12;
    localparam int WS    = EW + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] cs_sel = '0;
    logic lk_a = 1'b1, lk_b = 1'b1;
    logic [NB*EW-1:0] es = '0, ee = '0;
    logic [NB*PW-1:0] pmap_v = '0;
    logic [DW-1:0] rd_data = '0;
    logic rd_en, wr_en, busy, done, fail;
    logic [PW-1:0] reg_addr;
    logic [DW-1:0] wr_data;
    logic [WS-1:0] win_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_skew_prealign u_rx_skew_prealign (
        .clk(clk), .rst(rst), .start(start), .cs_sel(cs_sel),
        .lock_lo2hi(lk_a), .lock_hi2lo(lk_b), .edge_start(es), .edge_end(ee),
        .pad_map(pmap_v), .rd_data(rd_data), .rd_en(rd_en), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy), .done(done),
        .fail(fail), .win_size(win_size)
    );

    // Delay register bank seen by the block
    logic [DW-1:0] bank [NPADS];
    always @(posedge clk) begin
        if (rd_en) rd_data <= bank[reg_addr];
        if (wr_en) bank[reg_addr] <= wr_data;
    end

    typedef struct {
        bit rd; bit wr; int addr; int data; bit dn; bit fl;
    } rec_t;
    rec_t q[$];

    int checks = 0, errors = 0;
    int mbank [NPADS];
    bit mmask [NCS];
    int exp_win = 0;
    int s_in [NB];
    int e_in [NB];
    int pm [NB] = '{3, 7, 0, 11, 5, 4, 9, 1};
    int seed [NPADS] = '{2, 5, 9, 14, 18, 21, 22, 25, 12, 0, 7, 30};

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model's expected trace
    always @(negedge clk) begin
        rec_t x;
        bit   b;
        if (!rst) begin
            if (q.size() > 0) begin
                x = q.pop_front();
                b = 1'b1;
            end else begin
                x = '{0, 0, 0, 0, 0, 0};
                b = 1'b0;
            end
            checks++;
            if (rd_en !== x.rd || wr_en !== x.wr || busy !== b ||
                ((x.rd || x.wr) && int'(reg_addr) != x.addr) ||
                (x.wr && int'(wr_data) != x.data)) begin
                errors++;
                $display("FAIL R8 access: actual rd=%0b wr=%0b busy=%0b addr=%0d data=%0d expected rd=%0b wr=%0b busy=%0b addr=%0d data=%0d",
                         rd_en, wr_en, busy, reg_addr, wr_data, x.rd, x.wr, b, x.addr, x.data);
            end
            checks++;
            if (done !== x.dn || fail !== x.fl) begin
                errors++;
                $display("FAIL R9 done/fail: actual=%0b/%0b expected=%0b/%0b",
                         done, fail, x.dn, x.fl);
            end
        end
    end

    task automatic push_access(input int a);
        int nw;
        nw = (mbank[a] + 10 > 31) ? 31 : mbank[a] + 10;
        q.push_back('{1, 0, a, 0, 0, 0});
        q.push_back('{0, 1, a, nw, 0, 0});
        mbank[a] = nw;
    endtask

    task automatic model_pass(input int cs, input bit la, input bit lb);
        int mx, mn;
        mx = 0; mn = 63;
        for (int i = 0; i < NB; i++) begin
            if (s_in[i] > mx) mx = s_in[i];
            if (e_in[i] < mn) mn = e_in[i];
        end
        if (mmask[cs]) begin
            q.push_back('{0, 0, 0, 0, 1, 0});          // R2
        end else begin
            mmask[cs] = 1'b1;
            if (!(la && lb)) begin
                q.push_back('{0, 0, 0, 0, 1, 1});      // R3
            end else begin
                exp_win = mn - mx + 1;                 // R4
                if (mx <= 1)
                    for (int i = 0; i < NB; i++) push_access(pm[i]);   // R5
                if (mn > 30) begin                     // R6, R7
                    push_access(4);
                    push_access(5);
                end
                q.push_back('{0, 0, 0, 0, 1, 0});
            end
        end
    endtask

    task automatic run(input int cs, input bit la, input bit lb, input bit poke);
        @(posedge clk); #1;
        cs_sel = 2'(cs); lk_a = la; lk_b = lb;
        for (int i = 0; i < NB; i++) begin
            es[i*EW +: EW] = EW'(s_in[i]);
            ee[i*EW +: EW] = EW'(e_in[i]);
        end
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        model_pass(cs, la, lb);
        if (poke) begin
            // R9: a request while busy must not be taken
            @(posedge clk); #1; cs_sel = 2'd3; start = 1'b1;
            @(posedge clk); #1; start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
        chk(int'(win_size) == (exp_win & 255), "R4", "window size",
            int'(win_size), exp_win & 255);
        for (int p = 0; p < NPADS; p++)
            chk(int'(bank[p]) == mbank[p], "R5", $sformatf("bank pad %0d", p),
                int'(bank[p]), mbank[p]);
    endtask

    task automatic check_idle();
        chk(!busy && !done && !fail && !rd_en && !wr_en, "R1", "idle outputs",
            {busy, done, fail, rd_en, wr_en}, 0);
        chk(win_size == '0, "R1", "window after reset", int'(win_size), 0);
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst = 1'b1;
        repeat (2) @(posedge clk);
        #1; rst = 1'b0;
        q.delete();
        for (int c = 0; c < NCS; c++) mmask[c] = 1'b0;
        exp_win = 0;
        check_idle();
    endtask

    initial begin
        for (int i = 0; i < NB; i++) pmap_v[i*PW +: PW] = PW'(pm[i]);
        for (int p = 0; p < NPADS; p++) begin
            bank[p]  = DW'(seed[p]);
            mbank[p] = seed[p];
        end
        for (int c = 0; c < NCS; c++) mmask[c] = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        check_idle();

        // R4, R10-like: centered window, nothing to fix
        s_in = '{3, 5, 4, 3, 5, 4, 3, 4};
        e_in = '{20, 25, 22, 21, 24, 23, 20, 22};
        run(0, 1, 1, 0);

        // R2: same chip select again with a left-pressed window -> skipped
        s_in = '{0, 0, 0, 0, 0, 0, 0, 0};
        run(0, 1, 1, 0);

        // R5 with mapping and saturation, plus R9 ignored start while busy
        s_in = '{0, 1, 0, 1, 0, 0, 1, 0};
        e_in = '{20, 26, 22, 21, 24, 23, 20, 22};
        run(1, 1, 1, 1);

        // R6: right-pressed window
        s_in = '{4, 2, 3, 4, 1, 3, 2, 2};
        e_in = '{31, 40, 33, 35, 31, 38, 32, 36};
        run(2, 1, 1, 0);

        // R7: both fixes; chip select 3 still free, so the poke was ignored
        s_in = '{1, 0, 1, 1, 0, 1, 0, 1};
        e_in = '{35, 40, 36, 45, 50, 38, 39, 41};
        run(3, 1, 1, 0);

        // R1: reset clears the marks
        do_reset();

        // R6 boundary: largest start 2, smallest end 30
        s_in = '{2, 0, 1, 2, 0, 1, 1, 2};
        e_in = '{30, 31, 32, 30, 33, 34, 35, 36};
        run(0, 1, 1, 0);

        // R3: missing lock
        s_in = '{0, 0, 0, 0, 0, 0, 0, 0};
        e_in = '{40, 40, 40, 40, 40, 40, 40, 40};
        run(1, 0, 1, 0);
        // R3: mark set even on failure -> second attempt skipped
        run(1, 1, 1, 0);
        run(2, 1, 0, 0);

        // R4: negative window
        s_in = '{20, 12, 15, 18, 11, 14, 16, 13};
        e_in = '{10, 22, 25, 30, 28, 26, 24, 29};
        run(3, 1, 1, 0);

        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule